// File: doc/BRIEF.md
# Single-Level Page Table Walker

This block handles a translation-cache miss. It takes the missing page number and the kind of access, and reads that page's entry from a table held in main memory. It then reports either a translation or a trap. Two registers set where the table starts and how many entries it has. Software writes them through a small configuration port, and only privileged writes change them. The walker first compares the page number with the table length. A page number that is out of range is trapped at once and no memory read is issued. A page number that is in range costs exactly one read on a valid/ready memory request port.

The fetched 32-bit entry holds the frame number, a valid flag and three permission flags. When the entry is valid and permits the requested access, the walker returns the frame number, the permission flags and the physical address, which is the frame followed by the page offset. In the same cycle it drives a fill interface carrying the page-to-frame pair, so that a translation cache can install it. An entry that is not present, or that does not allow the access, produces a trap status and no fill.

Top module: `ptw_top`

## Requirements
- R1: After synchronous reset, `req_ready` is 1, and `mem_req_valid`, `resp_valid` and `fill_valid` are 0. The table base and table length are both 0, so any walk after reset is a bounds trap.
- R2: While the walker is idle, a write with `cfg_wr_en`=1 and `cfg_wr_priv`=1 is acknowledged in the same cycle on `cfg_wr_ack`. It loads the table base when `cfg_wr_sel`=0, and the table length (low PN_W+1 data bits) when `cfg_wr_sel`=1.
- R3: A write with `cfg_wr_priv`=0 is acknowledged but changes neither register.
- R4: While a walk is in progress, `cfg_wr_ack` stays 0 and neither register changes. A write that is held on the port is taken in the first idle cycle.
- R5: A page number greater than or equal to the table length gives `resp_status`=1 (bounds trap). The response comes 2 cycles after the request is accepted, and no memory read is issued.
- R6: For an in-range page, the read address is base + page number × 4. The address is held stable while `mem_req_valid` waits for `mem_req_ready`.
- R7: Each in-range miss issues exactly one memory read. The response is driven in the cycle after `mem_rsp_valid` is seen.
- R8: The entry layout is: bits [31:12] frame number, [3] valid, [2] execute, [1] write, [0] read. The other bits are ignored. If the valid bit is clear, the walker returns `resp_status`=2 and no fill.
- R9: `req_kind` values: 0 = read, 1 = write, 2 = execute, 3 = reserved. An access whose permission bit is clear, or of kind 3, returns `resp_status`=3 and no fill.
- R10: On success, `resp_status`=0 and the response carries the frame, the permission bits {x,w,r} and `resp_paddr` = {frame, offset}. In the same cycle `fill_valid` carries the page, frame and permission bits.
- R11: Requests are accepted only while `req_ready` is 1, which holds only when the walker is idle. `resp_valid` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Configuration write request |
| cfg_wr_sel | input | 1 | 0 selects table base, 1 selects table length |
| cfg_wr_priv | input | 1 | Write comes from privileged mode |
| cfg_wr_data | input | 32 | Write data |
| cfg_wr_ack | output | 1 | Write taken this cycle |
| req_valid | input | 1 | Miss request present |
| req_ready | output | 1 | Walker can accept a miss |
| req_vpn | input | PN_W | Missing page number |
| req_offset | input | 12 | Page offset of the access |
| req_kind | input | 2 | Access kind |
| mem_req_valid | output | 1 | Table read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 32 | Entry word |
| resp_valid | output | 1 | Walk result pulse |
| resp_status | output | 2 | 0 ok, 1 bounds, 2 not present, 3 permission |
| resp_frame | output | 20 | Frame number |
| resp_perm | output | 3 | Permission bits {x,w,r} |
| resp_paddr | output | 32 | Physical address |
| fill_valid | output | 1 | Install a translation |
| fill_vpn | output | PN_W | Page number to install |
| fill_frame | output | 20 | Frame number to install |
| fill_perm | output | 3 | Permission bits to install |

## Verification
The bench counts cycles from the clock edge that accepts a request. A bounds trap is due 2 cycles after that edge. An in-range walk reaches its read request 2 cycles after acceptance and responds on the cycle after the memory data, so its result is due 4 cycles after acceptance, plus the cycles the bench holds back ready and the cycles it holds back data. The memory model inserts those delays on purpose, and each scenario checks that the result arrives in exactly the computed cycle and that `resp_valid` is gone one cycle later. Configuration acknowledges are combinational, so the bench samples them shortly after driving the write. For stalled writes it confirms that no acknowledge appears before the walk has responded.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    localparam int ADDR_W         = 32;
    localparam int PTE_W          = 32;
    localparam int OFF_W          = 12;
    localparam int FRAME_W        = PTE_W - OFF_W;
    localparam int PTE_BYTES_LOG2 = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_READ_REQ,
        ST_READ_WAIT,
        ST_RESPOND
    } walk_state_e;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } access_e;

    typedef enum logic [1:0] {
        RS_OK      = 2'd0,
        RS_BOUNDS  = 2'd1,
        RS_INVALID = 2'd2,
        RS_PERM    = 2'd3
    } status_e;

    typedef struct packed {
        logic x;
        logic w;
        logic r;
    } perm_t;

    typedef struct packed {
        logic [FRAME_W-1:0] frame;
        logic               present;
        perm_t              perm;
    } pte_t;

    function automatic pte_t unpack_pte(input logic [PTE_W-1:0] word);
        pte_t e;
        e.frame   = word[PTE_W-1:OFF_W];
        e.present = word[3];
        e.perm    = perm_t'(word[2:0]);
        return e;
    endfunction

    function automatic logic perm_allows(input perm_t p, input access_e k);
        case (k)
            ACC_READ:  return p.r;
            ACC_WRITE: return p.w;
            ACC_EXEC:  return p.x;
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/ptw_cfg_regs.sv
module ptw_cfg_regs
    import ptw_pkg::*;
#(
    parameter int PN_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic              wr_priv,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic              walker_idle,
    output logic              wr_ack,
    output logic [ADDR_W-1:0] tbl_base,
    output logic [PN_W:0]     tbl_limit
);

    assign wr_ack = wr_en & walker_idle;

    always_ff @(posedge clk) begin
        if (rst) begin
            tbl_base  <= '0;
            tbl_limit <= '0;
        end else if (wr_ack && wr_priv) begin
            if (wr_sel) tbl_limit <= wr_data[PN_W:0];
            else        tbl_base  <= wr_data;
        end
    end

    assert_cfg_frozen_R4: assert property (@(posedge clk) disable iff (rst)
        !walker_idle |=> ($stable(tbl_base) && $stable(tbl_limit)));

    assert_unpriv_ignored_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_priv) |=> ($stable(tbl_base) && $stable(tbl_limit)));

endmodule

// File: rtl/ptw_pte_check.sv
module ptw_pte_check
    import ptw_pkg::*;
(
    input  logic [PTE_W-1:0]   pte_word,
    input  logic [1:0]         kind,
    output status_e            status,
    output logic [FRAME_W-1:0] frame,
    output perm_t              perm
);

    pte_t entry;

    always_comb begin
        entry = unpack_pte(pte_word);
        frame = entry.frame;
        perm  = entry.perm;
        if (!entry.present)
            status = RS_INVALID;
        else if (!perm_allows(entry.perm, access_e'(kind)))
            status = RS_PERM;
        else
            status = RS_OK;
    end

endmodule

// File: rtl/ptw_walk_fsm.sv
module ptw_walk_fsm
    import ptw_pkg::*;
#(
    parameter int PN_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [PN_W-1:0]   req_vpn,
    input  logic [OFF_W-1:0]  req_off,
    input  logic [1:0]        req_kind,
    input  logic [ADDR_W-1:0] tbl_base,
    input  logic [PN_W:0]     tbl_limit,
    input  logic              mem_req_ready,
    input  logic              mem_rsp_valid,
    input  logic [PTE_W-1:0]  mem_rsp_data,
    output logic              req_ready,
    output logic              walker_idle,
    output logic              mem_req_valid,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic              resp_valid,
    output logic              bounds_fault,
    output logic [PTE_W-1:0]  pte_word,
    output logic [PN_W-1:0]   vpn_q,
    output logic [OFF_W-1:0]  off_q,
    output logic [1:0]        kind_q
);

    walk_state_e state_q;
    logic        out_of_range;

    assign out_of_range  = ({1'b0, vpn_q} >= tbl_limit);
    assign walker_idle   = (state_q == ST_IDLE);
    assign req_ready     = walker_idle;
    assign mem_req_valid = (state_q == ST_READ_REQ);
    assign resp_valid    = (state_q == ST_RESPOND);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= ST_IDLE;
            vpn_q        <= '0;
            off_q        <= '0;
            kind_q       <= '0;
            pte_word     <= '0;
            bounds_fault <= 1'b0;
            mem_req_addr <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (req_valid) begin
                    vpn_q        <= req_vpn;
                    off_q        <= req_off;
                    kind_q       <= req_kind;
                    pte_word     <= '0;
                    bounds_fault <= 1'b0;
                    state_q      <= ST_CHECK;
                end
                ST_CHECK: if (out_of_range) begin
                    bounds_fault <= 1'b1;
                    state_q      <= ST_RESPOND;
                end else begin
                    mem_req_addr <= tbl_base + (ADDR_W'(vpn_q) << PTE_BYTES_LOG2);
                    state_q      <= ST_READ_REQ;
                end
                ST_READ_REQ: if (mem_req_ready) state_q <= ST_READ_WAIT;
                ST_READ_WAIT: if (mem_rsp_valid) begin
                    pte_word <= mem_rsp_data;
                    state_q  <= ST_RESPOND;
                end
                ST_RESPOND: state_q <= ST_IDLE;
                default:    state_q <= ST_IDLE;
            endcase
        end
    end

    assert_read_in_range_R5: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> ({1'b0, vpn_q} < tbl_limit));

    assert_addr_held_R6: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    assert_resp_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        resp_valid |=> !resp_valid);

    assert_busy_after_accept_R11: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

endmodule

// File: rtl/ptw_top.sv
module ptw_top
    import ptw_pkg::*;
#(
    parameter int PN_W = 20
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_wr_en,
    input  logic               cfg_wr_sel,
    input  logic               cfg_wr_priv,
    input  logic [31:0]        cfg_wr_data,
    output logic               cfg_wr_ack,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [PN_W-1:0]    req_vpn,
    input  logic [11:0]        req_offset,
    input  logic [1:0]         req_kind,
    output logic               mem_req_valid,
    input  logic               mem_req_ready,
    output logic [31:0]        mem_req_addr,
    input  logic               mem_rsp_valid,
    input  logic [31:0]        mem_rsp_data,
    output logic               resp_valid,
    output logic [1:0]         resp_status,
    output logic [19:0]        resp_frame,
    output logic [2:0]         resp_perm,
    output logic [31:0]        resp_paddr,
    output logic               fill_valid,
    output logic [PN_W-1:0]    fill_vpn,
    output logic [19:0]        fill_frame,
    output logic [2:0]         fill_perm
);

    logic [ADDR_W-1:0]  tbl_base;
    logic [PN_W:0]      tbl_limit;
    logic               walker_idle;
    logic               bounds_fault;
    logic [PTE_W-1:0]   pte_word;
    logic [PN_W-1:0]    vpn_q;
    logic [OFF_W-1:0]   off_q;
    logic [1:0]         kind_q;
    status_e            entry_status;
    logic [FRAME_W-1:0] entry_frame;
    perm_t              entry_perm;

    ptw_cfg_regs #(.PN_W(PN_W)) u_cfg (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (cfg_wr_en),
        .wr_sel      (cfg_wr_sel),
        .wr_priv     (cfg_wr_priv),
        .wr_data     (cfg_wr_data),
        .walker_idle (walker_idle),
        .wr_ack      (cfg_wr_ack),
        .tbl_base    (tbl_base),
        .tbl_limit   (tbl_limit)
    );

    ptw_walk_fsm #(.PN_W(PN_W)) u_fsm (
        .clk           (clk),
        .rst           (rst),
        .req_valid     (req_valid),
        .req_vpn       (req_vpn),
        .req_off       (req_offset),
        .req_kind      (req_kind),
        .tbl_base      (tbl_base),
        .tbl_limit     (tbl_limit),
        .mem_req_ready (mem_req_ready),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .req_ready     (req_ready),
        .walker_idle   (walker_idle),
        .mem_req_valid (mem_req_valid),
        .mem_req_addr  (mem_req_addr),
        .resp_valid    (resp_valid),
        .bounds_fault  (bounds_fault),
        .pte_word      (pte_word),
        .vpn_q         (vpn_q),
        .off_q         (off_q),
        .kind_q        (kind_q)
    );

    ptw_pte_check u_chk (
        .pte_word (pte_word),
        .kind     (kind_q),
        .status   (entry_status),
        .frame    (entry_frame),
        .perm     (entry_perm)
    );

    always_comb begin
        resp_status = bounds_fault ? RS_BOUNDS : entry_status;
        resp_frame  = entry_frame;
        resp_perm   = entry_perm;
        resp_paddr  = {entry_frame, off_q};
        fill_valid  = resp_valid && !bounds_fault && (entry_status == RS_OK);
        fill_vpn    = vpn_q;
        fill_frame  = entry_frame;
        fill_perm   = entry_perm;
    end

    assert_fill_only_on_ok_R10: assert property (@(posedge clk) disable iff (rst)
        fill_valid |-> (resp_valid && resp_status == RS_OK));

    assert_no_read_while_idle_R11: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (!mem_req_valid && !resp_valid));

endmodule

// File: tb/sim_ptw_top.sv
module sim_ptw_top;

    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] BASE_A = 32'h0001_0000;
    localparam logic [31:0] BASE_B = 32'h0004_0000;

    logic        clk = 0;
    logic        rst;
    logic        cfg_wr_en = 0, cfg_wr_sel = 0, cfg_wr_priv = 0;
    logic [31:0] cfg_wr_data = '0;
    logic        cfg_wr_ack;
    logic        req_valid = 0, req_ready;
    logic [19:0] req_vpn = '0;
    logic [11:0] req_offset = '0;
    logic [1:0]  req_kind = '0;
    logic        mem_req_valid, mem_req_ready = 0;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 0;
    logic [31:0] mem_rsp_data = '0;
    logic        resp_valid;
    logic [1:0]  resp_status;
    logic [19:0] resp_frame;
    logic [2:0]  resp_perm;
    logic [31:0] resp_paddr;
    logic        fill_valid;
    logic [19:0] fill_vpn, fill_frame;
    logic [2:0]  fill_perm;

    int total = 0;
    int bad = 0;

    logic [1:0]  r_status;
    logic [19:0] r_frame, r_fvpn, r_fframe;
    logic [2:0]  r_perm, r_fperm;
    logic [31:0] r_paddr, r_addr;
    logic        r_fill, r_mid_ready, r_after;
    int          r_lat, r_reads;
    bit          walk_done;

    ptw_top u0 (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic sel, input logic [31:0] data, input logic priv, input string req);
        @(negedge clk);
        cfg_wr_en = 1; cfg_wr_sel = sel; cfg_wr_data = data; cfg_wr_priv = priv;
        #1;
        check({req, " write ack"}, cfg_wr_ack, 1);
        @(negedge clk);
        cfg_wr_en = 0; cfg_wr_priv = 0;
    endtask

    task automatic do_walk(input logic [19:0] vpn, input logic [11:0] off, input logic [1:0] kind,
                           input logic [31:0] word, input int rdy_dly, input int rsp_dly);
        int wcnt = 0;
        int rcnt = 0;
        bit pend = 0;
        walk_done = 0; r_lat = 0; r_reads = 0; r_addr = '0; r_fill = 0; r_status = '0;
        @(negedge clk);
        req_valid = 1; req_vpn = vpn; req_offset = off; req_kind = kind;
        @(posedge clk);
        @(negedge clk);
        req_valid = 0;
        r_mid_ready = req_ready;
        for (int c = 1; c < 100; c++) begin
            if (c > 1) @(negedge clk);
            mem_req_ready = 0; mem_rsp_valid = 0;
            if (resp_valid) begin
                r_lat = c; r_status = resp_status; r_frame = resp_frame; r_perm = resp_perm;
                r_paddr = resp_paddr; r_fill = fill_valid; r_fvpn = fill_vpn;
                r_fframe = fill_frame; r_fperm = fill_perm;
                break;
            end
            if (mem_req_valid) begin
                if (wcnt == rdy_dly) begin
                    mem_req_ready = 1; r_addr = mem_req_addr; r_reads++; pend = 1;
                end else wcnt++;
            end else if (pend) begin
                if (rcnt == rsp_dly) begin
                    mem_rsp_valid = 1; mem_rsp_data = word; pend = 0;
                end else rcnt++;
            end
        end
        walk_done = 1;
        @(negedge clk);
        r_after = resp_valid;
    endtask

    task automatic t_ok(input string req, input logic [31:0] base, input logic [19:0] vpn,
                        input logic [11:0] off, input logic [1:0] kind, input logic [31:0] word,
                        input int rdy_dly, input int rsp_dly);
        do_walk(vpn, off, kind, word, rdy_dly, rsp_dly);
        check({req, " status ok"}, r_status, 0);
        check({req, " latency R7"}, r_lat, 4 + rdy_dly + rsp_dly);
        check({req, " one read R7"}, r_reads, 1);
        check({req, " entry addr R6"}, r_addr, base + {vpn, 2'b00});
        check({req, " frame R8"}, r_frame, word[31:12]);
        check({req, " perm R8"}, r_perm, word[2:0]);
        check({req, " paddr R10"}, r_paddr, {word[31:12], off});
        check({req, " fill R10"}, {r_fill, r_fvpn, r_fframe, r_fperm}, {1'b1, vpn, word[31:12], word[2:0]});
        check({req, " busy R11"}, r_mid_ready, 0);
        check({req, " pulse R11"}, r_after, 0);
    endtask

    task automatic t_fault(input string req, input logic [19:0] vpn, input logic [1:0] kind,
                           input logic [31:0] word, input logic [1:0] exp_st);
        do_walk(vpn, 12'h0, kind, word, 0, 0);
        check({req, " status"}, r_status, exp_st);
        check({req, " no fill"}, r_fill, 0);
        check({req, " reads"}, r_reads, (exp_st == 2'd1) ? 0 : 1);
        check({req, " latency"}, r_lat, (exp_st == 2'd1) ? 2 : 4);
        check({req, " pulse R11"}, r_after, 0);
    endtask

    task automatic test_reset;
        check("R1 req_ready", req_ready, 1);
        check("R1 mem_req_valid", mem_req_valid, 0);
        check("R1 resp_valid", resp_valid, 0);
        check("R1 fill_valid", fill_valid, 0);
        t_fault("R1 zero length R5", 20'd0, 2'd0, 32'h0, 2'd1);
    endtask

    task automatic test_config_and_ok;
        cfg_write(1'b0, BASE_A, 1'b1, "R2 base");
        cfg_write(1'b1, 32'd8, 1'b1, "R2 length");
        t_ok("R2 R10 read", BASE_A, 20'd3, 12'h5A4, 2'd0, 32'hABCDE_009, 0, 0);
        t_ok("R6 R7 delayed write last page", BASE_A, 20'd7, 12'hFFF, 2'd1, 32'h12345_00A, 2, 3);
        t_ok("R8 reserved bits ignored exec", BASE_A, 20'd0, 12'h001, 2'd2, 32'h00F0F_FF4C, 1, 0);
    endtask

    task automatic test_faults;
        t_fault("R5 page equals length", 20'd8, 2'd0, 32'hFFFFF_00F, 2'd1);
        t_fault("R5 page far beyond", 20'hFFFFF, 2'd0, 32'hFFFFF_00F, 2'd1);
        t_fault("R8 not present", 20'd2, 2'd0, 32'h11111_007, 2'd2);
        t_fault("R9 write to read-only", 20'd4, 2'd1, 32'h22222_009, 2'd3);
        t_fault("R9 exec without x", 20'd5, 2'd2, 32'h33333_00B, 2'd3);
        t_fault("R9 reserved kind", 20'd6, 2'd3, 32'h44444_00F, 2'd3);
    endtask

    task automatic test_unpriv;
        cfg_write(1'b0, BASE_B, 1'b0, "R3 base");
        cfg_write(1'b1, 32'd1, 1'b0, "R3 length");
        t_ok("R3 regs unchanged", BASE_A, 20'd6, 12'h010, 2'd0, 32'h55555_009, 0, 0);
    endtask

    task automatic test_stall;
        bit early = 0;
        int waited = 0;
        fork
            do_walk(20'd1, 12'h0, 2'd0, 32'h66666_009, 3, 2);
            begin
                repeat (3) @(negedge clk);
                cfg_wr_en = 1; cfg_wr_sel = 0; cfg_wr_data = BASE_B; cfg_wr_priv = 1;
                #1;
                while (!cfg_wr_ack && waited < 50) begin
                    @(negedge clk); #1; waited++;
                end
                if (cfg_wr_ack && !walk_done) early = 1;
                check("R4 ack eventually", cfg_wr_ack, 1);
                @(negedge clk);
                cfg_wr_en = 0; cfg_wr_priv = 0;
            end
        join
        check("R4 no ack during walk", early, 0);
        check("R4 walk used old base", r_addr, BASE_A + 32'd4);
        t_ok("R4 held write applied", BASE_B, 20'd2, 12'h0, 2'd0, 32'h77777_009, 0, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        @(negedge clk);
        test_reset();
        test_config_and_ok();
        test_faults();
        test_unpriv();
        test_stall();
        repeat (2) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule